// File: doc/BRIEF.md
# Dual-Channel Bus-Master Register Front End

This block is the register face of a two-channel storage bus-master DMA controller. A byte-addressed I/O window of 16 bytes gives each channel 8 bytes. The low half of each channel's slot is a control area that holds a command byte and a status byte. The high half holds a 32-bit descriptor-table base address. The block applies the status byte's rules: some bits are written directly, one is read-only, some are cleared by writing a one, and the rest always read zero. It gives the DMA engine per-channel inputs that set status flags. It drives the start and direction command bits and the descriptor base to the engine.

The block also merges the interrupts. Each channel's drive interrupt is registered into a per-channel configuration flag, the bit 7 of configuration byte 0x70 + ch*8. The flags are ORed onto a single interrupt output. That output is live only while the programmable interrupt-line byte is nonzero.

Top module: `ide_busmaster_regs`

## Requirements
- R1: The window decodes the channel as `io_addr[3]`. `io_addr[2]=0` selects the control area and `io_addr[2]=1` selects the descriptor area. In the control area a byte read at offset 0 returns the command byte and offset 2 returns the status byte. Offsets 1 and 3 read 0xFF and ignore writes.
- R2: The size code is `io_size`, with 0 for byte, 1 for word, 2 for dword and 3 reserved. In the control area, a read whose size is not a byte returns all ones for its width: 0xFFFF for a word, 0xFFFFFFFF for a dword or for the reserved code. A write whose size is not a byte changes nothing.
- R3: A command write keeps only bit 0 (start) and bit 3 (direction). All other command bits read zero. Bit 0 drives `dma_start[ch]` and bit 3 drives `dma_dir[ch]` from the cycle after the write.
- R4: A command write with bit 0 clear also clears status bit 0 (active).
- R5: A status write has four effects:
  - bits 5 and 6 take the written value;
  - bit 0 is unchanged;
  - bits 1 and 2 are cleared where the data holds a one and kept where it holds a zero;
  - bits 3, 4 and 7 read zero.
- R6: In each channel, `eng_active_set`, `eng_err_set` and `eng_irq_set` set status bits 0, 1 and 2. A set applies after any register write in the same cycle, so a set wins over a clear.
- R7: The descriptor base is 32 bits and bits 1:0 always read zero. An access at offset `io_addr[1:0]` with byte, word or dword size covers the bytes from that offset upward, and bytes past the 4-byte area are dropped. A read returns those bytes at bit 0 with zeros above. A reserved-size access reads all ones and writes nothing.
- R8: `irq_flag[ch]` (bit 7 of configuration byte 0x70 + ch*8) equals `drive_irq[ch]` as sampled at the previous clock edge.
- R9: `irq_out` is the OR of the channel flags while `int_line` is nonzero, and 0 while `int_line` is zero.
- R10: `int_line` resets to 0x0E. A write through `line_wr` stores only bits 3:0 and bits 7:4 read zero. `int_pin` always reads 0x01.
- R11: Reset clears every command byte, status byte and descriptor base, and both interrupt flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe for the I/O window |
| io_addr | input | 4 | Byte address inside the window |
| io_size | input | 2 | Access size code |
| io_wdata | input | 32 | Write data, least significant byte at the access offset |
| io_rdata | output | 32 | Read data for the current address and size |
| eng_active_set | input | 2 | Per-channel set of status bit 0 |
| eng_err_set | input | 2 | Per-channel set of status bit 1 |
| eng_irq_set | input | 2 | Per-channel set of status bit 2 |
| drive_irq | input | 2 | Per-channel drive interrupt level |
| line_wr | input | 1 | Write strobe for the interrupt-line byte |
| line_wdata | input | 8 | Interrupt-line write data |
| int_line | output | 8 | Interrupt-line byte |
| int_pin | output | 8 | Interrupt-pin byte |
| irq_flag | output | 2 | Per-channel configuration interrupt flag |
| dma_start | output | 2 | Per-channel start command bit |
| dma_dir | output | 2 | Per-channel direction command bit |
| prd_base | output | 64 | Descriptor bases, channel 0 in bits 31:0 |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default of two channels. This makes the channel-select address bit and the OR of two independent interrupt flags both reachable, so a mix-up between the channel slots or a lost flag shows up in the compare. The 8-byte channel stride puts every unaligned descriptor access, including the ones that run past the end of the 4-byte area, inside the address range that random traffic covers. With a 32-bit descriptor base, partial-byte merges of adjacent word and byte writes can be observed through reads.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  localparam logic [7:0] CMD_KEEP   = 8'h09;  // start (bit 0), direction (bit 3)
  localparam logic [7:0] STS_PLAIN  = 8'h60;  // bits written directly
  localparam logic [7:0] STS_W1C    = 8'h06;  // error, interrupt
  localparam logic [7:0] STS_ACTIVE = 8'h01;
  localparam logic [7:0] LINE_RST   = 8'h0E;
  localparam logic [7:0] LINE_WMASK = 8'h0F;
  localparam logic [7:0] PIN_VALUE  = 8'h01;

  function automatic logic [31:0] size_ones(acc_size_e sz);
    case (sz)
      SZ_BYTE:  size_ones = 32'h0000_00FF;
      SZ_WORD:  size_ones = 32'h0000_FFFF;
      default:  size_ones = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] size_lanes(acc_size_e sz);
    case (sz)
      SZ_BYTE:  size_lanes = 4'b0001;
      SZ_WORD:  size_lanes = 4'b0011;
      SZ_DWORD: size_lanes = 4'b1111;
      default:  size_lanes = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/ide_bm_rst_sync.sv
module ide_bm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
#(
  parameter int ADDR_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic                 sts_we,
  input  logic [7:0]           wbyte,
  input  logic [ADDR_BITS/8-1:0] prd_lanes,
  input  logic [ADDR_BITS-1:0] prd_wdata,
  input  logic                 set_act,
  input  logic                 set_err,
  input  logic                 set_int,
  output logic [7:0]           cmd_q,
  output logic [7:0]           sts_q,
  output logic [ADDR_BITS-1:0] prd_q
);

  localparam int LANES = ADDR_BITS / 8;

  logic [7:0]           cmd_d;
  logic [7:0]           sts_d;
  logic [ADDR_BITS-1:0] prd_d;
  logic                 cmd_en;
  logic                 sts_en;
  logic                 prd_en;

  // command and status next state
  always_comb begin
    cmd_d = cmd_q;
    sts_d = sts_q;
    if (cmd_we) begin
      cmd_d = wbyte & CMD_KEEP;
      if (!wbyte[0]) sts_d = sts_d & ~STS_ACTIVE;
    end
    if (sts_we) begin
      sts_d = (wbyte & STS_PLAIN) | (sts_q & STS_ACTIVE) | (sts_q & ~wbyte & STS_W1C);
    end
    sts_d[0] = sts_d[0] | set_act;
    sts_d[1] = sts_d[1] | set_err;
    sts_d[2] = sts_d[2] | set_int;
  end

  // descriptor base: per-lane merge
  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      if (ln == 0) begin : g_low
        always_comb begin
          prd_d[7:0] = prd_lanes[0] ? {prd_wdata[7:2], 2'b00} : prd_q[7:0];
        end
      end else begin : g_hi
        always_comb begin
          prd_d[ln*8 +: 8] = prd_lanes[ln] ? prd_wdata[ln*8 +: 8] : prd_q[ln*8 +: 8];
        end
      end
    end
  endgenerate

  assign cmd_en = cmd_we;
  assign sts_en = cmd_we | sts_we | set_act | set_err | set_int;
  assign prd_en = |prd_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prd_q <= '0;
    else if (prd_en) prd_q <= prd_d;
  end

  AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & ~CMD_KEEP) == 8'h00);  // R3
  AST_STOP_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !wbyte[0] && !set_act |=> !sts_q[0]);  // R4
  AST_STS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & 8'h98) == 8'h00);  // R5
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[1] && !(sts_we && wbyte[1]) |=> sts_q[1]);  // R5
  AST_ENGINE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_int |=> sts_q[2]);  // R6
  AST_PRD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    prd_q[1:0] == 2'b00);  // R7

endmodule

// File: rtl/ide_bm_irq.sv
module ide_bm_irq
  import ide_bm_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] drive_irq,
  input  logic           line_we,
  input  logic [7:0]     line_wdata,
  output logic [NCH-1:0] flag_q,
  output logic [7:0]     line_q,
  output logic           irq_out
);

  logic [NCH-1:0] flag_d;
  logic [7:0]     line_d;

  always_comb begin
    flag_d = drive_irq;
    line_d = line_wdata & LINE_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= LINE_RST;
    else if (line_we) line_q <= line_d;
  end

  assign irq_out = (|flag_q) && (line_q != 8'h00);

  AST_FLAG_FOLLOWS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flag_q == $past(drive_irq));  // R8
  AST_QUIET_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(|drive_irq) |=> !irq_out);  // R9
  AST_LINE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_q[7:4] == 4'h0);  // R10

endmodule

// File: rtl/ide_busmaster_regs.sv
module ide_busmaster_regs
  import ide_bm_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int ADDR_BITS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     io_wr,
  input  logic [3:0]               io_addr,
  input  logic [1:0]               io_size,
  input  logic [31:0]              io_wdata,
  output logic [31:0]              io_rdata,
  input  logic [NCH-1:0]           eng_active_set,
  input  logic [NCH-1:0]           eng_err_set,
  input  logic [NCH-1:0]           eng_irq_set,
  input  logic [NCH-1:0]           drive_irq,
  input  logic                     line_wr,
  input  logic [7:0]               line_wdata,
  output logic [7:0]               int_line,
  output logic [7:0]               int_pin,
  output logic [NCH-1:0]           irq_flag,
  output logic [NCH-1:0]           dma_start,
  output logic [NCH-1:0]           dma_dir,
  output logic [NCH*ADDR_BITS-1:0] prd_base,
  output logic                     irq_out
);

  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int LANES = ADDR_BITS / 8;

  logic            rst_q_n;
  acc_size_e       sz;
  logic [CH_W-1:0] ch_sel;
  logic            in_range;
  logic            sub_desc;
  logic [1:0]      off;
  logic            is_byte;
  logic [7:0]      lanes_wide;
  logic [3:0]      lanes;
  logic [31:0]     wdata_sh;

  logic [7:0]           cmd_q [NCH];
  logic [7:0]           sts_q [NCH];
  logic [ADDR_BITS-1:0] prd_q [NCH];

  ide_bm_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  // address decode
  always_comb begin
    sz         = acc_size_e'(io_size);
    ch_sel     = CH_W'(io_addr[3]);
    in_range   = (int'(ch_sel) < NCH);
    sub_desc   = io_addr[2];
    off        = io_addr[1:0];
    is_byte    = (sz == SZ_BYTE);
    lanes_wide = {4'b0000, size_lanes(sz)} << off;
    lanes      = lanes_wide[3:0];
    wdata_sh   = io_wdata << {off, 3'b000};
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      logic cmd_we;
      logic sts_we;
      logic [LANES-1:0] prd_lanes;

      always_comb begin
        hit       = io_wr && in_range && (int'(ch_sel) == c);
        cmd_we    = hit && !sub_desc && is_byte && (off == 2'd0);
        sts_we    = hit && !sub_desc && is_byte && (off == 2'd2);
        prd_lanes = (hit && sub_desc) ? LANES'(lanes) : '0;
      end

      ide_bm_chan #(.ADDR_BITS(ADDR_BITS)) u_chan (
        .clk       (clk),
        .rst_n     (rst_q_n),
        .cmd_we    (cmd_we),
        .sts_we    (sts_we),
        .wbyte     (io_wdata[7:0]),
        .prd_lanes (prd_lanes),
        .prd_wdata (ADDR_BITS'(wdata_sh)),
        .set_act   (eng_active_set[c]),
        .set_err   (eng_err_set[c]),
        .set_int   (eng_irq_set[c]),
        .cmd_q     (cmd_q[c]),
        .sts_q     (sts_q[c]),
        .prd_q     (prd_q[c])
      );

      assign dma_start[c] = cmd_q[c][0];
      assign dma_dir[c]   = cmd_q[c][3];
      assign prd_base[c*ADDR_BITS +: ADDR_BITS] = prd_q[c];
    end
  endgenerate

  // read path
  always_comb begin
    io_rdata = 32'h0000_0000;
    if (!in_range) begin
      io_rdata = size_ones(sz);
    end else if (!sub_desc) begin
      if (!is_byte) begin
        io_rdata = size_ones(sz);
      end else begin
        case (off)
          2'd0:    io_rdata = {24'h0, cmd_q[ch_sel]};
          2'd2:    io_rdata = {24'h0, sts_q[ch_sel]};
          default: io_rdata = 32'h0000_00FF;
        endcase
      end
    end else if (sz == SZ_RSVD) begin
      io_rdata = 32'hFFFF_FFFF;
    end else begin
      io_rdata = (32'(prd_q[ch_sel]) >> {off, 3'b000}) & size_ones(sz);
    end
  end

  ide_bm_irq #(.NCH(NCH)) u_irq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .drive_irq  (drive_irq),
    .line_we    (line_wr),
    .line_wdata (line_wdata),
    .flag_q     (irq_flag),
    .line_q     (int_line),
    .irq_out    (irq_out)
  );

  assign int_pin = PIN_VALUE;

  AST_WIDE_CTL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_q_n)
    io_wr && !sub_desc && !is_byte |=> $stable(dma_start) && $stable(dma_dir));  // R2
  AST_CTL_NO_DESC_CHANGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    io_wr && !sub_desc |=> $stable(prd_base));  // R1
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_q_n |-> (prd_base == '0) && (dma_start == '0) && (irq_flag == '0));  // R11

endmodule

// File: tb/sim_ide_busmaster_regs.sv
`timescale 1ns/1ps
module sim_ide_busmaster_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [1:0]  eng_active_set = '0, eng_err_set = '0, eng_irq_set = '0, drive_irq = '0;
  logic        line_wr = 1'b0;
  logic [7:0]  line_wdata = '0;
  logic [7:0]  int_line, int_pin;
  logic [1:0]  irq_flag, dma_start, dma_dir;
  logic [63:0] prd_base;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  ide_busmaster_regs u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .eng_active_set(eng_active_set),
    .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set), .drive_irq(drive_irq),
    .line_wr(line_wr), .line_wdata(line_wdata), .int_line(int_line), .int_pin(int_pin),
    .irq_flag(irq_flag), .dma_start(dma_start), .dma_dir(dma_dir), .prd_base(prd_base),
    .irq_out(irq_out)
  );

  // behavioural reference model
  logic [7:0]  m_cmd [2];
  logic [7:0]  m_sts [2];
  logic [31:0] m_prd [2];
  logic [1:0]  m_flag;
  logic [7:0]  m_line;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cmd[c] = 8'h00; m_sts[c] = 8'h00; m_prd[c] = 32'h0;
      end
      m_flag = 2'b00;
      m_line = 8'h0E;
    end else begin
      if (io_wr) begin
        int c, o, n, pos;
        logic [7:0] wb;
        c  = io_addr / 8;
        o  = io_addr % 8;
        wb = io_wdata[7:0];
        n  = (io_size == 0) ? 1 : (io_size == 1) ? 2 : (io_size == 2) ? 4 : 0;
        if (o < 4) begin
          if (io_size == 0 && o == 0) begin
            m_cmd[c] = wb & 8'h09;
            if (!wb[0]) m_sts[c][0] = 1'b0;
          end else if (io_size == 0 && o == 2) begin
            m_sts[c] = (wb & 8'h60) | (m_sts[c] & 8'h01) | (m_sts[c] & ~wb & 8'h06);
          end
        end else begin
          for (int k = 0; k < n; k++) begin
            pos = o - 4 + k;
            if (pos < 4) m_prd[c][pos*8 +: 8] = io_wdata[k*8 +: 8];
          end
          m_prd[c][1:0] = 2'b00;
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (eng_active_set[c]) m_sts[c][0] = 1'b1;
        if (eng_err_set[c])    m_sts[c][1] = 1'b1;
        if (eng_irq_set[c])    m_sts[c][2] = 1'b1;
      end
      m_flag = drive_irq;
      if (line_wr) m_line = line_wdata & 8'h0F;
    end
  end

  function automatic logic [31:0] exp_read(logic [3:0] a, logic [1:0] s);
    int c, o, n;
    logic [31:0] r;
    c = a / 8; o = a % 8;
    n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    r = 32'h0;
    if (o < 4) begin
      if (s != 0) r = (s == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
      else if (o == 0) r = {24'h0, m_cmd[c]};
      else if (o == 2) r = {24'h0, m_sts[c]};
      else r = 32'h0000_00FF;
    end else if (s == 3) begin
      r = 32'hFFFF_FFFF;
    end else begin
      for (int k = 0; k < n; k++)
        if (o - 4 + k < 4) r[k*8 +: 8] = m_prd[c][(o-4+k)*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(dma_start == {m_cmd[1][0], m_cmd[0][0]}, "R3 start", dma_start, {m_cmd[1][0], m_cmd[0][0]});
    check(dma_dir == {m_cmd[1][3], m_cmd[0][3]}, "R3 dir", dma_dir, {m_cmd[1][3], m_cmd[0][3]});
    check(prd_base == {m_prd[1], m_prd[0]}, "R7 base", prd_base, {m_prd[1], m_prd[0]});
    check(irq_flag == m_flag, "R8 flag", irq_flag, m_flag);
    check(irq_out == ((|m_flag) && (m_line != 0)), "R9 irq", irq_out, (|m_flag) && (m_line != 0));
    check(int_line == m_line, "R10 line", int_line, m_line);
    check(io_rdata == exp_read(io_addr, io_size), "R1 read", io_rdata, exp_read(io_addr, io_size));
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    compare_all();
  endtask

  task automatic idle();
    io_wr = 0; eng_active_set = 0; eng_err_set = 0; eng_irq_set = 0; line_wr = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    io_addr = a; io_size = s; io_wdata = d; io_wr = 1;
    step();
    idle();
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] s, input logic [31:0] exp, input string tag);
    io_addr = a; io_size = s;
    #1;
    check(io_rdata == exp, tag, io_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) step();

    // R11 reset state, R10 reset line and pin
    check(prd_base == 64'h0, "R11 base after reset", prd_base, 0);
    check(dma_start == 2'b00 && irq_flag == 2'b00, "R11 start/flag after reset", {dma_start, irq_flag}, 0);
    rd(4'h2, 0, 32'h00, "R11 status ch0 after reset");
    rd(4'h8, 0, 32'h00, "R11 command ch1 after reset");
    check(int_line == 8'h0E, "R10 line reset", int_line, 8'h0E);
    check(int_pin == 8'h01, "R10 pin", int_pin, 8'h01);

    // R3 command masking
    wr(4'h0, 0, 32'hFF);
    rd(4'h0, 0, 32'h09, "R3 command keeps bits 0 and 3");
    check(dma_start[0] && dma_dir[0], "R3 outputs", {dma_start[0], dma_dir[0]}, 2'b11);

    // R6 engine sets
    eng_active_set = 2'b01; eng_err_set = 2'b01; eng_irq_set = 2'b01;
    step(); idle();
    rd(4'h2, 0, 32'h07, "R6 engine sets status");

    // R5 status write rule: 0x62 on 0x07 -> 0x65
    wr(4'h2, 0, 32'h62);
    rd(4'h2, 0, 32'h65, "R5 status write");

    // R4 stop clears active
    wr(4'h0, 0, 32'h08);
    rd(4'h2, 0, 32'h64, "R4 stop clears active");

    // R2 wide control accesses
    wr(4'h0, 1, 32'h0001);
    rd(4'h0, 0, 32'h08, "R2 word write ignored");
    rd(4'h2, 1, 32'h0000_FFFF, "R2 word read all ones");
    rd(4'h0, 2, 32'hFFFF_FFFF, "R2 dword read all ones");
    // R1 spare offsets
    wr(4'h3, 0, 32'h00);
    rd(4'h2, 0, 32'h64, "R1 spare offset write ignored");
    rd(4'h1, 0, 32'hFF, "R1 spare offset reads FF");

    // R1 channel 1 slot
    wr(4'h8, 0, 32'h01);
    rd(4'h8, 0, 32'h01, "R1 channel 1 command");
    rd(4'h0, 0, 32'h08, "R1 channel 0 untouched");

    // R7 descriptor base
    wr(4'hC, 2, 32'h1234_5677);
    rd(4'hC, 2, 32'h1234_5674, "R7 dword write aligned");
    wr(4'h4, 0, 32'hAB);
    wr(4'h6, 1, 32'hBEEF);
    rd(4'h4, 2, 32'hBEEF_00A8, "R7 byte and word merge");
    rd(4'h6, 1, 32'h0000_BEEF, "R7 word read");

    // R8 and R9 interrupt path
    drive_irq = 2'b10;
    step();
    check(irq_flag == 2'b10, "R8 flag set", irq_flag, 2'b10);
    check(irq_out == 1'b1, "R9 irq with line nonzero", irq_out, 1);
    line_wr = 1; line_wdata = 8'hF0;
    step(); idle();
    check(int_line == 8'h00, "R10 upper bits dropped", int_line, 0);
    check(irq_out == 1'b0, "R9 gated by zero line", irq_out, 0);
    line_wr = 1; line_wdata = 8'h05;
    step(); idle();
    check(irq_out == 1'b1, "R9 regated", irq_out, 1);
    drive_irq = 2'b00;
    step();
    check(irq_flag == 2'b00, "R8 flag cleared", irq_flag, 0);

    // R6 set wins over clear in the same cycle
    io_addr = 4'hA; io_size = 0; io_wdata = 32'h06; io_wr = 1; eng_err_set = 2'b10;
    step(); idle();
    rd(4'hA, 0, 32'h02, "R6 set wins over clear");

    // random traffic, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      io_wr          = ($urandom_range(0, 2) == 0);
      io_addr        = 4'($urandom_range(0, 15));
      io_size        = 2'($urandom_range(0, 3));
      io_wdata       = $urandom;
      eng_active_set = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      eng_err_set    = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      eng_irq_set    = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      if ($urandom_range(0, 5) == 0) drive_irq = 2'($urandom);
      line_wr        = ($urandom_range(0, 30) == 0);
      line_wdata     = 8'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule